// File: doc/BRIEF.md
# I2C Bit Timing Engine

This block turns single-bit bus primitives into open-drain SCL and SDA waveforms for an I2C master. A sequencer puts one primitive on the request port: start condition, repeated start, stop condition, transmit one bit, or receive one bit. The engine reports that the primitive has finished with a one-cycle done pulse. Transmit and receive bits leave SCL driven low when they finish, so bytes and acknowledge slots can follow one another without a gap on the bus.

The length of the SCL high phase and the length of the SCL low phase come from two separate count inputs, so the duty cycle can be unequal (for example about 36/64 for fast mode). A hold count sets how long SDA stays unchanged after SCL falls. A 32-bit configuration word carries the enable flag and the hold count. Software works out every count from the input clock rate; the engine does no frequency arithmetic. The outputs are pull-low enables for the two lines. A released line reads high through the external pull-up.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset both pull-low outputs are 0, `busy` is 0 and `done` is 0.
- R2: Bit 0 of `cfg_word` is the enable. While it is 0, both lines are released by the next clock edge, `busy` stays 0, and any request is ignored. No line changes and no done pulse occur.
- R3: Request codes on `req_op` are: 0 start, 1 repeated start, 2 stop, 3 send bit, 4 receive bit. A request is taken on a clock edge where `req_valid` is 1, the engine is enabled and `busy` is 0. `busy` is 1 from that edge until the edge that raises `done`. A request made while busy is ignored. Codes 5 to 7 are ignored.
- R4: For a send or receive request taken at edge A, SCL is driven low from edge A and released at edge A+max(L,H)+1. L is `scl_low_cnt` and H is the hold count. SCL is driven low again, together with the done pulse, `scl_high_cnt`+1 edges after its release.
- R5: The hold count is `cfg_word[23:8]`. In every primitive that starts with SCL low, SDA takes its new level at edge A+H+1 and not before.
- R6: A sent bit drives SDA low for a 0 and releases it for a 1. SDA does not change while SCL is released during a send or receive.
- R7: A receive releases SDA. It samples `sda_in` at the edge that is ceil(`scl_high_cnt`/2)+1 edges after SCL release. It presents that value on `rx_bit` from that edge through the done pulse.
- R8: A start releases both lines at edge A. It pulls SDA low `scl_high_cnt`+1 edges later while SCL is released. After the same interval again it pulls SCL low and raises `done`.
- R9: A stop drives SDA low in the low phase and then releases SCL. SDA is released `scl_high_cnt`+1 edges after the SCL release, which is a rising SDA edge while SCL is high. `done` follows after the same interval again, with both lines left released.
- R10: A repeated start releases SDA in the low phase and then releases SCL. It then runs the start timing of R8 from that SCL release.
- R11: With all counts at 0, each SCL phase lasts one clock, so a bit takes two clocks. This is the fastest rate, half the input clock.
- R12: Clearing the enable during a primitive aborts it. At the next edge both lines are released and `busy` is 0, and no done pulse follows.

Top module ports (in port-list order):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Bit 0 enable, bits 23:8 SDA hold count |
| scl_high_cnt | input | CNT_W | SCL released phase, count plus one clocks |
| scl_low_cnt | input | CNT_W | SCL low phase, count plus one clocks |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Primitive code |
| req_bit | input | 1 | Bit value for a send |
| sda_in | input | 1 | Sampled SDA line level |
| busy | output | 1 | A primitive is in progress |
| done | output | 1 | One-cycle pulse when a primitive finishes |
| rx_bit | output | 1 | Last received bit |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Each line transition and each done pulse is predicted as an edge number counted from the accepting edge. A phase counter that loads or decrements wrongly therefore shows up at the very first SCL or SDA transition of the affected primitive as an off-by-some-cycles timestamp. A hold counter that ends early moves the SDA change ahead of its predicted edge in the same bit. A wrong state transition gives a line level that does not match, or a done pulse that nothing predicted, within one primitive. Receive sampling is checked by giving `sda_in` the wanted value on the predicted sample edge only, so sampling one cycle early or late returns the inverted bit.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int CFG_W    = 32;
  localparam int EN_BIT   = 0;
  localparam int HOLD_LSB = 8;
  localparam int HOLD_W   = 16;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_STOP    = 3'd2,
    OP_SEND    = 3'd3,
    OP_RECV    = 3'd4
  } bt_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOW, S_HIGH, S_SSETUP, S_SHOLD, S_PSETUP, S_PFREE
  } bt_state_e;
endpackage

// File: rtl/bt_rst_sync.sv
module bt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/bt_downcount.sv
module bt_downcount #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (dec && cnt_q != '0) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign value = cnt_q;
  assign zero  = (cnt_q == '0);

  // a count that has reached zero must not wrap when decremented further
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load && zero) |=> zero);
endmodule

// File: rtl/bt_rx_capture.sv
module bt_rx_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic din,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (strobe) q <= din;
  end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
  import bt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [CNT_W-1:0] scl_high_cnt,
  input  logic [CNT_W-1:0] scl_low_cnt,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic             req_bit,
  input  logic             sda_in,
  output logic             busy,
  output logic             done,
  output logic             rx_bit,
  output logic             scl_drive_low,
  output logic             sda_drive_low
);
  localparam int LOW_W = (CNT_W > HOLD_W) ? CNT_W : HOLD_W;

  logic              rst_i_n;
  logic              en;
  logic [HOLD_W-1:0] hold_cnt;
  logic              cfg_unused;

  bt_state_e st_q, st_d;
  bt_op_e    op_q, op_d;
  logic      tgt_q, tgt_d;
  logic      scl_q, scl_d, sda_q, sda_d, done_q, done_d;
  logic      accept;

  logic              ph_load, ph_dec, ph_zero;
  logic [LOW_W-1:0]  ph_val, ph_load_val;
  logic              hd_load, hd_dec, hd_zero;
  logic [HOLD_W-1:0] hd_val_unused;
  logic              smp;
  logic [CNT_W-1:0]  mid_point;

  assign en         = cfg_word[EN_BIT];
  assign hold_cnt   = cfg_word[HOLD_LSB +: HOLD_W];
  assign cfg_unused = ^{cfg_word[CFG_W-1:HOLD_LSB+HOLD_W], cfg_word[HOLD_LSB-1:EN_BIT+1]};
  assign mid_point  = scl_high_cnt >> 1;
  assign accept     = en && (st_q == S_IDLE) && req_valid;

  bt_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  bt_downcount #(.W(LOW_W)) u_phase (
    .clk(clk), .rst_n(rst_i_n), .load(ph_load), .dec(ph_dec),
    .load_val(ph_load_val), .value(ph_val), .zero(ph_zero));

  bt_downcount #(.W(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_i_n), .load(hd_load), .dec(hd_dec),
    .load_val(hold_cnt), .value(hd_val_unused), .zero(hd_zero));

  bt_rx_capture u_rx (
    .clk(clk), .rst_n(rst_i_n), .strobe(smp), .din(sda_in), .q(rx_bit));

  // next-state logic
  always_comb begin
    st_d        = st_q;
    op_d        = op_q;
    tgt_d       = tgt_q;
    scl_d       = scl_q;
    sda_d       = sda_q;
    done_d      = 1'b0;
    ph_load     = 1'b0;
    ph_dec      = 1'b0;
    ph_load_val = LOW_W'(scl_high_cnt);
    hd_load     = 1'b0;
    hd_dec      = 1'b0;
    smp         = 1'b0;
    if (!en) begin
      st_d  = S_IDLE;
      scl_d = 1'b0;
      sda_d = 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          op_d = bt_op_e'(req_op);
          case (bt_op_e'(req_op))
            OP_START: begin
              st_d    = S_SSETUP;
              scl_d   = 1'b0;
              sda_d   = 1'b0;
              ph_load = 1'b1;
            end
            OP_RESTART, OP_STOP, OP_SEND, OP_RECV: begin
              st_d        = S_LOW;
              scl_d       = 1'b1;
              ph_load     = 1'b1;
              ph_load_val = LOW_W'(scl_low_cnt);
              hd_load     = 1'b1;
              tgt_d       = (bt_op_e'(req_op) == OP_STOP) ||
                            ((bt_op_e'(req_op) == OP_SEND) && !req_bit);
            end
            default: st_d = S_IDLE;
          endcase
        end
        S_LOW: begin
          ph_dec = 1'b1;
          hd_dec = 1'b1;
          if (hd_zero) sda_d = tgt_q;
          if (hd_zero && ph_zero) begin
            scl_d   = 1'b0;
            ph_load = 1'b1;
            st_d    = (op_q == OP_RESTART) ? S_SSETUP :
                      (op_q == OP_STOP)    ? S_PSETUP : S_HIGH;
          end
        end
        S_HIGH: begin
          ph_dec = 1'b1;
          smp    = (op_q == OP_RECV) && (ph_val == LOW_W'(mid_point));
          if (ph_zero) begin
            scl_d  = 1'b1;
            done_d = 1'b1;
            st_d   = S_IDLE;
          end
        end
        S_SSETUP, S_PSETUP: begin
          ph_dec = 1'b1;
          if (ph_zero) begin
            sda_d   = (st_q == S_SSETUP);
            ph_load = 1'b1;
            st_d    = (st_q == S_SSETUP) ? S_SHOLD : S_PFREE;
          end
        end
        S_SHOLD, S_PFREE: begin
          ph_dec = 1'b1;
          if (ph_zero) begin
            if (st_q == S_SHOLD) scl_d = 1'b1;
            done_d = 1'b1;
            st_d   = S_IDLE;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= S_IDLE;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_q  <= OP_START;
      tgt_q <= 1'b0;
    end else if (accept) begin
      op_q  <= op_d;
      tgt_q <= tgt_d;
    end
  end

  assign busy          = (st_q != S_IDLE);
  assign done          = done_q;
  assign scl_drive_low = scl_q;
  assign sda_drive_low = sda_q;

  p_off_release_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !en |=> (!scl_q && !sda_q && !busy));

  p_hold_wait_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (en && st_q == S_LOW && !hd_zero) |=> $stable(sda_q));

  p_bit_sda_stable_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (en && st_q == S_HIGH) |=> $stable(sda_q));

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(done_q) |-> $past(st_q != S_IDLE));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_q |=> !done_q);
endmodule

// File: tb/sim_i2c_bit_timer.sv
module sim_i2c_bit_timer;
  localparam int CLK_NS = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en = 1'b0;
  logic [15:0]   cfg_hold = '0;
  logic [31:0]   cfg_word;
  logic [CW-1:0] hi_c = '0, lo_c = '0;
  logic          req_valid = 1'b0, req_bit = 1'b0;
  logic [2:0]    req_op = '0;
  logic          slave_pull = 1'b0;
  logic          sda_in, busy, done, rx_bit, scl_oe, sda_oe;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  typedef struct {
    int    ed;
    logic  scl;
    logic  sda;
    logic  dn;
    logic  crx;
    logic  rx;
    string tag;
  } ev_t;
  ev_t  exp_q[$];
  logic m_scl = 1'b0, m_sda = 1'b0;
  logic prev_scl = 1'b0, prev_sda = 1'b0;

  assign cfg_word = {8'h00, cfg_hold, 7'h00, cfg_en};
  assign sda_in   = !(sda_oe || slave_pull);

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  i2c_bit_timer #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .scl_high_cnt(hi_c), .scl_low_cnt(lo_c),
    .req_valid(req_valid), .req_op(req_op), .req_bit(req_bit),
    .sda_in(sda_in), .busy(busy), .done(done), .rx_bit(rx_bit),
    .scl_drive_low(scl_oe), .sda_drive_low(sda_oe));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // expected event: line levels after edge ed, optional done and rx value
  task automatic set_ev(input int e, input logic s, input logic d, input logic dn,
                        input logic crx, input logic rx, input string tag);
    ev_t it;
    if (s != m_scl || d != m_sda || dn) begin
      if (exp_q.size() > 0 && exp_q[exp_q.size()-1].ed == e) begin
        it = exp_q.pop_back();
        it.scl = s; it.sda = d; it.dn = it.dn | dn;
        it.crx = it.crx | crx; it.rx = rx;
      end else begin
        it.ed = e; it.scl = s; it.sda = d; it.dn = dn;
        it.crx = crx; it.rx = rx; it.tag = tag;
      end
      exp_q.push_back(it);
    end
    m_scl = s;
    m_sda = d;
  endtask

  // monitor: every line change or done pulse is compared with the queue head
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (scl_oe != prev_scl || sda_oe != prev_sda || done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3", "unexpected bus event at edge", cyc, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(e.ed == cyc, e.tag, "event edge", cyc, e.ed);
          chk(scl_oe == e.scl, e.tag, "scl_drive_low", int'(scl_oe), int'(e.scl));
          chk(sda_oe == e.sda, e.tag, "sda_drive_low", int'(sda_oe), int'(e.sda));
          chk(done == e.dn, e.tag, "done", int'(done), int'(e.dn));
          if (e.crx) chk(rx_bit == e.rx, e.tag, "rx_bit", int'(rx_bit), int'(e.rx));
        end
      end
      prev_scl <= scl_oe;
      prev_sda <= sda_oe;
    end
  end

  task automatic run_op(input logic [2:0] op, input logic b, input bit poke,
                        input string tag);
    int a, mx, t2, t_end, ts, h, l, hd;
    logic tgt;
    h  = int'(hi_c);
    l  = int'(lo_c);
    hd = int'(cfg_hold);
    @(negedge clk);
    a  = cyc + 1;
    mx = (l > hd) ? l : hd;
    t2 = a + mx + 1;
    ts = t2 + (h + 1) / 2 + 1;
    if (op == 3'd0) begin
      set_ev(a, 0, 0, 0, 0, 0, tag);
      set_ev(a + h + 1, 0, 1, 0, 0, 0, tag);
      t_end = a + 2 * h + 2;
      set_ev(t_end, 1, 1, 1, 0, 0, tag);
    end else begin
      tgt = (op == 3'd2) || (op == 3'd3 && !b);
      set_ev(a, 1, m_sda, 0, 0, 0, tag);
      set_ev(a + hd + 1, 1, tgt, 0, 0, 0, tag);
      set_ev(t2, 0, tgt, 0, 0, 0, tag);
      if (op == 3'd1) begin
        set_ev(t2 + h + 1, 0, 1, 0, 0, 0, tag);
        t_end = t2 + 2 * h + 2;
        set_ev(t_end, 1, 1, 1, 0, 0, tag);
      end else if (op == 3'd2) begin
        set_ev(t2 + h + 1, 0, 0, 0, 0, 0, tag);
        t_end = t2 + 2 * h + 2;
        set_ev(t_end, 0, 0, 1, 0, 0, tag);
      end else begin
        t_end = t2 + h + 1;
        set_ev(t_end, 1, tgt, 1, (op == 3'd4), b, tag);
      end
    end
    req_valid = 1'b1; req_op = op; req_bit = b;
    @(negedge clk);
    req_valid = 1'b0;
    while (cyc < t_end) begin
      if (op == 3'd4) slave_pull = (cyc == ts - 1) ? !b : b;
      req_valid = poke && (cyc == a + 1);
      req_op    = 3'd0;
      @(negedge clk);
    end
    req_valid  = 1'b0;
    slave_pull = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(scl_oe == 0, "R1", "scl_drive_low", int'(scl_oe), 0);
    chk(sda_oe == 0, "R1", "sda_drive_low", int'(sda_oe), 0);
    chk(busy == 0, "R1", "busy", int'(busy), 0);
    chk(done == 0, "R1", "done", int'(done), 0);

    // asymmetric timing, hold shorter than low phase
    cfg_en = 1'b1; hi_c = 16'd4; lo_c = 16'd6; cfg_hold = 16'd2;
    @(negedge clk);
    run_op(3'd0, 0, 0, "R8");
    run_op(3'd3, 1, 0, "R4,R5,R6");
    run_op(3'd3, 0, 1, "R3,R4,R6");
    run_op(3'd4, 1, 0, "R7");
    hi_c = 16'd5;
    run_op(3'd4, 0, 0, "R7");
    run_op(3'd1, 0, 0, "R10");
    run_op(3'd3, 0, 0, "R5");
    run_op(3'd2, 0, 0, "R9");

    // hold longer than low phase: SDA change and SCL release meet
    hi_c = 16'd3; lo_c = 16'd3; cfg_hold = 16'd7;
    run_op(3'd0, 0, 0, "R8");
    run_op(3'd3, 0, 0, "R4,R5");
    run_op(3'd4, 1, 0, "R5,R7");
    run_op(3'd2, 0, 0, "R9");

    // fastest rate
    hi_c = '0; lo_c = '0; cfg_hold = '0;
    run_op(3'd0, 0, 0, "R11");
    run_op(3'd3, 1, 0, "R11");
    run_op(3'd3, 0, 0, "R11");
    run_op(3'd4, 1, 0, "R11");
    run_op(3'd2, 0, 0, "R11");

    // R3: undefined code ignored while idle
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd6;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 0, "R3", "busy after code 6", int'(busy), 0);
    repeat (5) @(negedge clk);

    // R12: abort in the middle of a send
    hi_c = 16'd10; lo_c = 16'd10; cfg_hold = 16'd2;
    run_op(3'd0, 0, 0, "R8");
    begin
      int a;
      @(negedge clk);
      a = cyc + 1;
      set_ev(a + 3, 1, 0, 0, 0, 0, "R12");
      set_ev(a + 5, 0, 0, 0, 0, 0, "R12");
      req_valid = 1'b1; req_op = 3'd3; req_bit = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (cyc < a + 4) @(negedge clk);
      cfg_en = 1'b0;
      @(negedge clk);
      chk(busy == 0, "R12", "busy after abort", int'(busy), 0);
      chk(scl_oe == 0 && sda_oe == 0, "R12", "lines after abort",
          int'({scl_oe, sda_oe}), 0);
    end
    repeat (10) @(negedge clk);

    // R2: request while disabled is ignored
    req_valid = 1'b1; req_op = 3'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 0, "R2", "busy while disabled", int'(busy), 0);
    repeat (12) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R2", "lines while disabled",
        int'({scl_oe, sda_oe}), 0);

    cfg_en = 1'b1;
    hi_c = 16'd2; lo_c = 16'd4; cfg_hold = 16'd1;
    run_op(3'd0, 0, 0, "R2,R8");
    run_op(3'd3, 0, 0, "R2,R6");
    run_op(3'd2, 0, 0, "R9");
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "events still pending", exp_q.size(), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule